// File: doc/BRIEF.md
# Invalidation Acknowledgement Collector

This block sits in a node hub beside one processor and keeps track of that processor's coherence transactions, up to four at a time. Each transaction takes a slot that holds its line address. Replies for the line come back from the home and from other caches, and they can arrive in any order. A write to a shared line gets two kinds of reply: a grant from the home that carries a count of invalidations, and one acknowledgement from each sharer that was invalidated. The block merges these into one completion. It raises that completion only when the grant has arrived and every acknowledgement it announced has also arrived. In this way the processor never sees a write finish before the other caches have dropped their copies, which preserves sequential consistency.

The same slots decide what happens to interventions that other requesters send for a line this processor holds. An intervention is serviced at once when the line is not busy. It is held back while a write to that line is still collecting acknowledgements, and it is then serviced in the cycle after that write completes. It is thrown away when the line has a writeback in flight. The block also handles these cases: a speculative reply from the home followed by a response from the owner, and a negative acknowledgement from the home, which makes the block reissue the request. A negatively acknowledged upgrade is reissued as a read-exclusive.

Each slot runs a small state machine with these states:
- `SL_IDLE`: the slot is free.
- `SL_WAIT_HOME`: the request has been issued and the home has not yet answered.
- `SL_WAIT_OWNER`: a speculative reply has arrived and the owner's response is awaited.
- `SL_COLLECT`: the grant has arrived and acknowledgements are still owed.
- `SL_WB`: a writeback is waiting for its acknowledgement.

The slot moves between states as follows:
- A request moves it from idle to `SL_WAIT_HOME`, or to `SL_WB` for a writeback.
- A shared reply ends the transaction.
- A grant ends the transaction when the count is already met. Otherwise it moves the slot to `SL_COLLECT`.
- A speculative reply moves the slot to `SL_WAIT_OWNER`.
- An owner response ends the transaction.
- The last acknowledgement in `SL_COLLECT` ends the transaction.
- A writeback acknowledgement ends the transaction.
- A negative acknowledgement keeps the slot in `SL_WAIT_HOME` and reissues the request.

Top module: `inv_ack_collector`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. One cycle later `out_valid` pulses with the same line and kind. The kind codes are 0 read, 1 read-exclusive, 2 upgrade and 3 writeback.
- R2: `req_ready` is low in any of three cases: a slot already holds the requested line, all four slots are busy, or a negative acknowledgement (`msg_type` 7) is on the message port in that cycle.
- R3: A shared data reply (`msg_type` 0) for a line waiting on the home completes the transaction. One cycle later `cpl_valid` pulses with the line, the kind and `msg_data`.
- R4: An exclusive data grant (`msg_type` 1) or an upgrade grant (`msg_type` 2) carries in `msg_count` the number of invalidation acknowledgements (`msg_type` 3) to expect. Completion follows the last of them by one cycle. It never follows the grant alone while acknowledgements are still owed.
- R5: Acknowledgements that arrive before the grant are counted. If they already match the grant's count, the completion follows the grant by one cycle.
- R6: After a speculative reply (`msg_type` 4), an owner data response (`msg_type` 5) completes the transaction with the owner's data. A data-less owner acknowledgement (`msg_type` 6) completes it with the speculative data instead.
- R7: A negative acknowledgement reissues the request on `out_*` one cycle later. An upgrade is reissued as a read-exclusive, and a later completion reports the read-exclusive kind. Other kinds are reissued unchanged.
- R8: An intervention (`msg_type` 9) for a line collecting acknowledgements is not serviced while collection goes on. `ivn_valid` pulses with that line in the same cycle as that write's `cpl_valid`.
- R9: An intervention for a line with a writeback outstanding pulses `ivn_drop` one cycle later and is not serviced. A writeback acknowledgement (`msg_type` 8) then completes the writeback.
- R10: An intervention for a line that no slot holds pulses `ivn_valid` with that line one cycle later.
- R11: A reply for a line that no slot holds is ignored and produces no completion.
- R12: After reset, `out_valid`, `cpl_valid`, `ivn_valid` and `ivn_drop` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor presents a request |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Request kind code |
| req_line | input | LINE_W | Line address of the request |
| msg_valid | input | 1 | Network message present |
| msg_type | input | 4 | Message type code |
| msg_line | input | LINE_W | Line the message refers to |
| msg_count | input | CNT_W | Acknowledgement count carried by a grant |
| msg_data | input | DATA_W | Data carried by a reply |
| out_valid | output | 1 | Request issued toward the home |
| out_kind | output | 2 | Kind of the issued request |
| out_line | output | LINE_W | Line of the issued request |
| cpl_valid | output | 1 | Transaction completed to the processor |
| cpl_kind | output | 2 | Kind of the completed transaction |
| cpl_line | output | LINE_W | Line of the completed transaction |
| cpl_data | output | DATA_W | Data returned with the completion |
| ivn_valid | output | 1 | Intervention to be serviced by the cache |
| ivn_line | output | LINE_W | Line of the serviced intervention |
| ivn_drop | output | 1 | Intervention discarded |

## Verification
Several wrong internal states show up at the ports in specific ways:
- A miscounted acknowledgement counter gives a completion one acknowledgement early or late, or never gives one at all. The bench checks `cpl_valid` one cycle after each grant and each acknowledgement, so a wrong count is seen at the first message where the count matters.
- A slot left in the wrong state shows up on the next intervention for its line: it is serviced, held or dropped wrongly in the following cycle.
- A slot that stays busy shows up as `req_ready` low for a request that should be accepted.
- A lost data selection shows up as the wrong `cpl_data` in the completion cycle.

// File: rtl/ackc_pkg.sv
package ackc_pkg;

    typedef enum logic [1:0] {
        RK_READ      = 2'd0,
        RK_RDEX      = 2'd1,
        RK_UPGRADE   = 2'd2,
        RK_WRITEBACK = 2'd3
    } req_kind_e;

    typedef enum logic [3:0] {
        MT_SHARED_DATA = 4'd0,
        MT_EXCL_DATA   = 4'd1,
        MT_UPG_GRANT   = 4'd2,
        MT_INV_ACK     = 4'd3,
        MT_SPEC_DATA   = 4'd4,
        MT_OWNER_DATA  = 4'd5,
        MT_OWNER_ACK   = 4'd6,
        MT_NACK        = 4'd7,
        MT_WB_ACK      = 4'd8,
        MT_INTERVENE   = 4'd9,
        MT_RSVD_A      = 4'd10,
        MT_RSVD_B      = 4'd11,
        MT_RSVD_C      = 4'd12,
        MT_RSVD_D      = 4'd13,
        MT_RSVD_E      = 4'd14,
        MT_RSVD_F      = 4'd15
    } msg_type_e;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_WAIT_HOME,
        SL_WAIT_OWNER,
        SL_COLLECT,
        SL_WB
    } slot_state_e;

endpackage

// File: rtl/ackc_line_match.sv
module ackc_line_match #(
    parameter int N      = 4,
    parameter int LINE_W = 26
) (
    input  logic [N-1:0]      busy_i,
    input  logic [LINE_W-1:0] lines_i [N],
    input  logic [LINE_W-1:0] probe_i,
    output logic [N-1:0]      hit_o,
    output logic              any_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = busy_i[g] && (lines_i[g] == probe_i);
    end
    assign any_o = |hit_o;
endmodule

// File: rtl/ackc_slot.sv
module ackc_slot
    import ackc_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  req_kind_e         alloc_kind_i,
    input  logic [LINE_W-1:0] alloc_line_i,
    input  logic              m_hit_i,
    input  msg_type_e         m_type_i,
    input  logic [CNT_W-1:0]  m_count_i,
    input  logic [DATA_W-1:0] m_data_i,
    output logic              busy_o,
    output logic [LINE_W-1:0] line_o,
    output logic              collect_o,
    output logic              wb_o,
    output logic              fin_o,
    output req_kind_e         fin_kind_o,
    output logic [DATA_W-1:0] fin_data_o,
    output logic              fin_defer_o,
    output logic              retry_o,
    output req_kind_e         retry_kind_o
);
    localparam int SW = CNT_W + 1;

    slot_state_e             state_q, state_d;
    req_kind_e               kind_q, kind_d;
    logic [LINE_W-1:0]       line_q, line_d;
    logic signed [SW-1:0]    cnt_q, cnt_d;
    logic [DATA_W-1:0]       data_q, data_d;
    logic                    defer_q, defer_d;
    logic signed [SW-1:0]    grant_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SL_IDLE;
            kind_q  <= RK_READ;
            line_q  <= '0;
            cnt_q   <= '0;
            data_q  <= '0;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            line_q  <= line_d;
            cnt_q   <= cnt_d;
            data_q  <= data_d;
            defer_q <= defer_d;
        end
    end

    assign grant_sum = cnt_q + $signed({1'b0, m_count_i});

    always_comb begin
        state_d      = state_q;
        kind_d       = kind_q;
        line_d       = line_q;
        cnt_d        = cnt_q;
        data_d       = data_q;
        defer_d      = defer_q;
        fin_o        = 1'b0;
        fin_data_o   = data_q;
        retry_o      = 1'b0;
        retry_kind_o = kind_q;
        unique case (state_q)
            SL_IDLE: begin
                if (alloc_i) begin
                    line_d  = alloc_line_i;
                    kind_d  = alloc_kind_i;
                    cnt_d   = '0;
                    data_d  = '0;
                    defer_d = 1'b0;
                    state_d = (alloc_kind_i == RK_WRITEBACK) ? SL_WB : SL_WAIT_HOME;
                end
            end
            SL_WAIT_HOME: begin
                if (m_hit_i) begin
                    unique case (m_type_i)
                        MT_SHARED_DATA: begin
                            fin_o      = 1'b1;
                            fin_data_o = m_data_i;
                            state_d    = SL_IDLE;
                        end
                        MT_EXCL_DATA, MT_UPG_GRANT: begin
                            if (m_type_i == MT_EXCL_DATA) begin
                                data_d = m_data_i;
                            end
                            if (grant_sum == '0) begin
                                fin_o      = 1'b1;
                                fin_data_o = (m_type_i == MT_EXCL_DATA) ? m_data_i : data_q;
                                state_d    = SL_IDLE;
                            end else begin
                                cnt_d   = grant_sum;
                                state_d = SL_COLLECT;
                            end
                        end
                        MT_INV_ACK: cnt_d = cnt_q - 1'b1;
                        MT_SPEC_DATA: begin
                            data_d  = m_data_i;
                            state_d = SL_WAIT_OWNER;
                        end
                        MT_NACK: begin
                            retry_o      = 1'b1;
                            retry_kind_o = (kind_q == RK_UPGRADE) ? RK_RDEX : kind_q;
                            kind_d       = retry_kind_o;
                        end
                        default: ;
                    endcase
                end
            end
            SL_WAIT_OWNER: begin
                if (m_hit_i && m_type_i == MT_OWNER_DATA) begin
                    fin_o      = 1'b1;
                    fin_data_o = m_data_i;
                    state_d    = SL_IDLE;
                end else if (m_hit_i && m_type_i == MT_OWNER_ACK) begin
                    fin_o      = 1'b1;
                    fin_data_o = data_q;
                    state_d    = SL_IDLE;
                end
            end
            SL_COLLECT: begin
                if (m_hit_i && m_type_i == MT_INV_ACK) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_d == '0) begin
                        fin_o   = 1'b1;
                        state_d = SL_IDLE;
                    end
                end else if (m_hit_i && m_type_i == MT_INTERVENE) begin
                    defer_d = 1'b1;
                end
            end
            SL_WB: begin
                if (m_hit_i && m_type_i == MT_WB_ACK) begin
                    fin_o   = 1'b1;
                    state_d = SL_IDLE;
                end
            end
            default: state_d = SL_IDLE;
        endcase
    end

    assign busy_o      = (state_q != SL_IDLE);
    assign line_o      = line_q;
    assign collect_o   = (state_q == SL_COLLECT);
    assign wb_o        = (state_q == SL_WB);
    assign fin_kind_o  = kind_q;
    assign fin_defer_o = defer_q;
endmodule

// File: rtl/inv_ack_collector.sv
module inv_ack_collector
    import ackc_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int LINE_W = 26,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [LINE_W-1:0] req_line,
    input  logic              msg_valid,
    input  logic [3:0]        msg_type,
    input  logic [LINE_W-1:0] msg_line,
    input  logic [CNT_W-1:0]  msg_count,
    input  logic [DATA_W-1:0] msg_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [LINE_W-1:0] out_line,
    output logic              cpl_valid,
    output logic [1:0]        cpl_kind,
    output logic [LINE_W-1:0] cpl_line,
    output logic [DATA_W-1:0] cpl_data,
    output logic              ivn_valid,
    output logic [LINE_W-1:0] ivn_line,
    output logic              ivn_drop
);
    logic [SLOTS-1:0]  busy, collect, wb, fin, defer, retry, req_hit, msg_hit, alloc, free1h;
    logic [LINE_W-1:0] s_line [SLOTS];
    req_kind_e         s_fkind [SLOTS];
    req_kind_e         s_rkind [SLOTS];
    logic [DATA_W-1:0] s_fdata [SLOTS];
    logic              req_any, msg_any, any_free, nack_now, accept;
    msg_type_e         mtype;

    assign mtype = msg_type_e'(msg_type);

    ackc_line_match #(.N(SLOTS), .LINE_W(LINE_W)) u_req_match (
        .busy_i(busy), .lines_i(s_line), .probe_i(req_line),
        .hit_o(req_hit), .any_o(req_any)
    );

    ackc_line_match #(.N(SLOTS), .LINE_W(LINE_W)) u_msg_match (
        .busy_i(busy), .lines_i(s_line), .probe_i(msg_line),
        .hit_o(msg_hit), .any_o(msg_any)
    );

    always_comb begin
        free1h   = '0;
        any_free = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!busy[i] && !any_free) begin
                free1h[i] = 1'b1;
                any_free  = 1'b1;
            end
        end
    end

    assign nack_now  = msg_valid && (mtype == MT_NACK);
    assign req_ready = any_free && !req_any && !nack_now;
    assign accept    = req_valid && req_ready;
    assign alloc     = accept ? free1h : '0;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        ackc_slot #(.LINE_W(LINE_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (alloc[g]),
            .alloc_kind_i (req_kind_e'(req_kind)),
            .alloc_line_i (req_line),
            .m_hit_i      (msg_valid && msg_hit[g]),
            .m_type_i     (mtype),
            .m_count_i    (msg_count),
            .m_data_i     (msg_data),
            .busy_o       (busy[g]),
            .line_o       (s_line[g]),
            .collect_o    (collect[g]),
            .wb_o         (wb[g]),
            .fin_o        (fin[g]),
            .fin_kind_o   (s_fkind[g]),
            .fin_data_o   (s_fdata[g]),
            .fin_defer_o  (defer[g]),
            .retry_o      (retry[g]),
            .retry_kind_o (s_rkind[g])
        );
    end

    logic              fin_any, fin_def, retry_any, ivn_now, drop_d, svc_now;
    logic [1:0]        fin_kind_m, retry_kind_m;
    logic [LINE_W-1:0] fin_line_m, retry_line_m;
    logic [DATA_W-1:0] fin_data_m;

    always_comb begin
        fin_any      = 1'b0;
        fin_def      = 1'b0;
        fin_kind_m   = '0;
        fin_line_m   = '0;
        fin_data_m   = '0;
        retry_any    = 1'b0;
        retry_kind_m = '0;
        retry_line_m = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (fin[i]) begin
                fin_any    = 1'b1;
                fin_def    = defer[i];
                fin_kind_m = s_fkind[i];
                fin_line_m = s_line[i];
                fin_data_m = s_fdata[i];
            end
            if (retry[i]) begin
                retry_any    = 1'b1;
                retry_kind_m = s_rkind[i];
                retry_line_m = s_line[i];
            end
        end
    end

    assign ivn_now = msg_valid && (mtype == MT_INTERVENE);
    assign drop_d  = ivn_now && |(msg_hit & wb);
    assign svc_now = ivn_now && msg_any ? !(|(msg_hit & (wb | collect))) : ivn_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= '0;
            out_line  <= '0;
            cpl_valid <= 1'b0;
            cpl_kind  <= '0;
            cpl_line  <= '0;
            cpl_data  <= '0;
            ivn_valid <= 1'b0;
            ivn_line  <= '0;
            ivn_drop  <= 1'b0;
        end else begin
            out_valid <= accept || retry_any;
            out_kind  <= retry_any ? retry_kind_m : req_kind;
            out_line  <= retry_any ? retry_line_m : req_line;
            cpl_valid <= fin_any;
            cpl_kind  <= fin_kind_m;
            cpl_line  <= fin_line_m;
            cpl_data  <= fin_data_m;
            ivn_valid <= svc_now || (fin_any && fin_def);
            ivn_line  <= svc_now ? msg_line : fin_line_m;
            ivn_drop  <= drop_d;
        end
    end
endmodule

// File: rtl/ackc_checker.sv
module ackc_checker #(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [LINE_W-1:0] req_line,
    input logic              msg_valid,
    input logic [3:0]        msg_type,
    input logic              out_valid,
    input logic [1:0]        out_kind,
    input logic [LINE_W-1:0] out_line,
    input logic              cpl_valid,
    input logic [1:0]        cpl_kind,
    input logic              ivn_drop
);
    // R1
    issue_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid && out_line == $past(req_line) && out_kind == $past(req_kind));

    // R7
    nacked_upgrade_promoted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(msg_valid && msg_type == 4'd7) |-> out_kind != 2'd2);

    // R3
    cpl_needs_message_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> $past(msg_valid));

    // R9
    drop_needs_intervention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivn_drop |-> $past(msg_valid && msg_type == 4'd9));

    // R9
    wb_cpl_after_wback_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && cpl_kind == 2'd3 |-> $past(msg_type) == 4'd8);
endmodule

bind inv_ack_collector ackc_checker #(.LINE_W(LINE_W)) u_ackc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_line(req_line), .msg_valid(msg_valid), .msg_type(msg_type),
    .out_valid(out_valid), .out_kind(out_kind), .out_line(out_line),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .ivn_drop(ivn_drop)
);

// File: tb/tb_inv_ack_collector.sv
`timescale 1ns/1ps
module tb_inv_ack_collector;
    localparam int LW = 26;
    localparam int DW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [LW-1:0] req_line = '0;
    logic          msg_valid = 1'b0;
    logic [3:0]    msg_type = '0;
    logic [LW-1:0] msg_line = '0;
    logic [CW-1:0] msg_count = '0;
    logic [DW-1:0] msg_data = '0;
    logic          out_valid, cpl_valid, ivn_valid, ivn_drop;
    logic [1:0]    out_kind, cpl_kind;
    logic [LW-1:0] out_line, cpl_line, ivn_line;
    logic [DW-1:0] cpl_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    inv_ack_collector #(.SLOTS(4), .LINE_W(LW), .DATA_W(DW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_line(req_line), .msg_valid(msg_valid),
        .msg_type(msg_type), .msg_line(msg_line), .msg_count(msg_count),
        .msg_data(msg_data), .out_valid(out_valid), .out_kind(out_kind),
        .out_line(out_line), .cpl_valid(cpl_valid), .cpl_kind(cpl_kind),
        .cpl_line(cpl_line), .cpl_data(cpl_data), .ivn_valid(ivn_valid),
        .ivn_line(ivn_line), .ivn_drop(ivn_drop)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [LW-1:0] l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_line = l;
        #1;
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(out_valid && out_line == l && out_kind == k, "R1 issue", {out_valid, out_kind, out_line}, {1'b1, k, l});
    endtask

    task automatic send(input logic [3:0] t, input logic [LW-1:0] l, input int c, input logic [DW-1:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_type = t; msg_line = l; msg_count = CW'(c); msg_data = d;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(!out_valid && !cpl_valid && !ivn_valid && !ivn_drop, "R12 outputs", {out_valid, cpl_valid, ivn_valid, ivn_drop}, 0);
        chk(req_ready == 1'b1, "R12 ready", req_ready, 1);
    endtask

    task automatic t_shared_read();
        issue(2'd0, 26'h100);
        send(4'd0, 26'h100, 0, 64'hAAAA_0001);
        chk(cpl_valid && cpl_line == 26'h100 && cpl_data == 64'hAAAA_0001 && cpl_kind == 2'd0,
            "R3 shared completion", cpl_data, 64'hAAAA_0001);
    endtask

    task automatic t_excl_two_acks();
        issue(2'd1, 26'h200);
        send(4'd1, 26'h200, 2, 64'hBEEF);
        chk(!cpl_valid, "R4 no completion on grant", cpl_valid, 0);
        send(4'd3, 26'h200, 0, 0);
        chk(!cpl_valid, "R4 no completion one ack short", cpl_valid, 0);
        send(4'd3, 26'h200, 0, 0);
        chk(cpl_valid && cpl_data == 64'hBEEF && cpl_line == 26'h200, "R4 completion after last ack", cpl_data, 64'hBEEF);
    endtask

    task automatic t_early_acks();
        issue(2'd2, 26'h300);
        send(4'd3, 26'h300, 0, 0);
        send(4'd3, 26'h300, 0, 0);
        chk(!cpl_valid, "R5 early acks alone", cpl_valid, 0);
        send(4'd2, 26'h300, 3, 0);
        chk(!cpl_valid, "R5 grant with one owed", cpl_valid, 0);
        send(4'd3, 26'h300, 0, 0);
        chk(cpl_valid && cpl_kind == 2'd2, "R5 completion after remaining ack", {cpl_valid, cpl_kind}, 3'b110);
        issue(2'd1, 26'h310);
        send(4'd3, 26'h310, 0, 0);
        send(4'd1, 26'h310, 1, 64'h55);
        chk(cpl_valid && cpl_data == 64'h55, "R5 grant meets early count", cpl_data, 64'h55);
    endtask

    task automatic t_spec();
        issue(2'd0, 26'h400);
        send(4'd4, 26'h400, 0, 64'h1111);
        chk(!cpl_valid, "R6 no completion on speculative", cpl_valid, 0);
        send(4'd5, 26'h400, 0, 64'h2222);
        chk(cpl_valid && cpl_data == 64'h2222, "R6 owner data overrides", cpl_data, 64'h2222);
        issue(2'd1, 26'h410);
        send(4'd4, 26'h410, 0, 64'h3333);
        send(4'd6, 26'h410, 0, 64'h9999);
        chk(cpl_valid && cpl_data == 64'h3333, "R6 owner ack keeps speculative", cpl_data, 64'h3333);
    endtask

    task automatic t_nack();
        issue(2'd2, 26'h500);
        @(negedge clk);
        msg_valid = 1'b1; msg_type = 4'd7; msg_line = 26'h500;
        req_valid = 1'b1; req_kind = 2'd0; req_line = 26'h777;
        #1;
        chk(!req_ready, "R2 ready low during nack", req_ready, 0);
        @(negedge clk);
        msg_valid = 1'b0; req_valid = 1'b0;
        chk(out_valid && out_kind == 2'd1 && out_line == 26'h500, "R7 upgrade reissued as rdex", out_kind, 1);
        send(4'd1, 26'h500, 0, 64'h77);
        chk(cpl_valid && cpl_kind == 2'd1, "R7 completion kind rdex", cpl_kind, 1);
        issue(2'd0, 26'h510);
        send(4'd7, 26'h510, 0, 0);
        chk(out_valid && out_kind == 2'd0 && out_line == 26'h510, "R7 read reissued unchanged", out_kind, 0);
        send(4'd0, 26'h510, 0, 64'h1);
        chk(cpl_valid, "R7 read completes after reissue", cpl_valid, 1);
    endtask

    task automatic t_stall();
        issue(2'd1, 26'h600);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_line = 26'h600;
        #1;
        chk(!req_ready, "R2 same line stalls", req_ready, 0);
        req_valid = 1'b0;
        issue(2'd1, 26'h601);
        issue(2'd1, 26'h602);
        issue(2'd1, 26'h603);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_line = 26'h604;
        #1;
        chk(!req_ready, "R2 all slots busy", req_ready, 0);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            send(4'd1, LW'(26'h600 + i), 0, 64'(i));
            chk(cpl_valid && cpl_line == LW'(26'h600 + i), "R4 zero count drains", cpl_line, 26'h600 + i);
        end
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_line = 26'h604;
        #1;
        chk(req_ready, "R2 ready after drain", req_ready, 1);
        req_valid = 1'b0;
    endtask

    task automatic t_defer();
        issue(2'd1, 26'h700);
        send(4'd1, 26'h700, 1, 64'hD0);
        send(4'd9, 26'h700, 0, 0);
        chk(!ivn_valid && !ivn_drop, "R8 intervention held", {ivn_valid, ivn_drop}, 0);
        send(4'd3, 26'h700, 0, 0);
        chk(cpl_valid && ivn_valid && ivn_line == 26'h700, "R8 serviced with completion", {cpl_valid, ivn_valid}, 3);
    endtask

    task automatic t_writeback();
        issue(2'd3, 26'h800);
        send(4'd9, 26'h800, 0, 0);
        chk(ivn_drop && !ivn_valid, "R9 intervention dropped", {ivn_drop, ivn_valid}, 2);
        send(4'd8, 26'h800, 0, 0);
        chk(cpl_valid && cpl_kind == 2'd3 && cpl_line == 26'h800, "R9 writeback completes", cpl_kind, 3);
    endtask

    task automatic t_free_intervention();
        send(4'd9, 26'h900, 0, 0);
        chk(ivn_valid && ivn_line == 26'h900 && !ivn_drop, "R10 serviced at once", ivn_line, 26'h900);
    endtask

    task automatic t_stray();
        send(4'd0, 26'hA00, 0, 64'h5);
        chk(!cpl_valid, "R11 stray reply ignored", cpl_valid, 0);
        send(4'd3, 26'hA00, 0, 0);
        chk(!cpl_valid && !out_valid, "R11 stray ack ignored", cpl_valid, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shared_read();
        t_excl_two_acks();
        t_early_acks();
        t_spec();
        t_nack();
        t_stall();
        t_defer();
        t_writeback();
        t_free_intervention();
        t_stray();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule